// File: doc/BRIEF.md
# MMU Control Register Access Unit

This unit sits between a processor's alternate-space load/store path and the control side of a memory management unit. Each access carries an address-space code, an address, write data and a read or write strobe. Two spaces are recognised. The register space reaches a sixteen-entry control register file. The command space issues TLB flush requests on stores and table-probe requests on loads. A load from any other space returns zero. A store to any other space is dropped.

In both recognised spaces, address bits 11:8 select the target. In the register space they give the register index. In the command space they give the flush or probe level. The register file applies its own rule to each entry:
- The control word keeps only its enable and no-fault bits.
- The context register is stored in full.
- The fault status and fault address registers ignore software stores. They are loaded from a hardware capture port instead.
- Fault status clears itself when it is read.

A change to the control word or to the context register requests a flush of the whole TLB, because translations cached under the old setting are no longer valid.

Every response comes one clock after its strobe. The one exception is a probe: the unit issues a one-cycle probe request, waits for the walker to return `probe_valid`, and forwards the returned data a cycle later. The host must issue no access while a probe is outstanding. Any access made during that time is dropped.

Top module: `mmu_ctl_regs`

## Requirements
- R1: After reset every register reads as zero, and `rd_valid`, `flush_page_req`, `flush_all_req` and `probe_req` are low.
- R2: A load in register space 4 returns the register selected by address bits 11:8. `rd_valid` and `rd_data` appear on the clock after the strobe.
- R3: A store to register 0 changes only bit 0 (enable) and bit 1 (no-fault). If either bit changes value, `flush_all_req` pulses on the clock after the strobe. Otherwise it stays low.
- R4: A store to register 2 keeps the full word. It raises `flush_all_req` on the next clock only if the value differs from the one held.
- R5: A load of register 3 returns its current value and then clears it to zero. A hardware capture (`hw_fault_we`) writes registers 3 and 4. If a capture and the clearing read fall in the same cycle, the captured value is kept.
- R6: Stores to registers 3 and 4 leave them unchanged. Stores to every other index except 0 and 2 write the full word and request no flush.
- R7: A store to command space 3 at level 0 pulses `flush_page_req`, with `flush_page_addr` equal to the address with bits 11:0 cleared.
- R8: A store to command space 3 at levels 1 to 4 pulses `flush_all_req`. At levels 5 to 15 it requests nothing.
- R9: A load from command space 3 at levels 0 to 4 pulses `probe_req`, carrying the level and the address, and gives no immediate read data. The data returned with `probe_valid` appears on `rd_data`, with `rd_valid`, one clock later.
- R10: A load from command space 3 at a level above 4 returns zero with `rd_valid` on the next clock and raises no `probe_req`.
- R11: A load from any space other than 3 or 4 returns zero with `rd_valid`. A store to such a space changes no register and requests nothing.
- R12: `flush_page_req`, `flush_all_req` and `probe_req` are single-cycle pulses, and a flush page request and a flush all request never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_space | input | 8 | Address-space code of the access |
| acc_addr | input | 32 | Access address; bits 11:8 select register or level |
| acc_wdata | input | 32 | Store data |
| acc_rd | input | 1 | Load strobe |
| acc_wr | input | 1 | Store strobe (takes precedence over a load) |
| hw_fault_we | input | 1 | Hardware fault capture strobe |
| hw_fault_status | input | 32 | Captured fault status |
| hw_fault_addr | input | 32 | Captured fault address |
| probe_valid | input | 1 | Probe result is valid |
| probe_data | input | 32 | Probe result |
| rd_valid | output | 1 | Load data valid |
| rd_data | output | 32 | Load data |
| flush_page_req | output | 1 | Single-page flush pulse |
| flush_page_addr | output | 32 | Page-aligned flush address |
| flush_all_req | output | 1 | Whole-TLB flush pulse |
| probe_req | output | 1 | Probe request pulse |
| probe_level | output | 4 | Probe level |
| probe_addr | output | 32 | Probe address |

## Verification
The bench targets several corner cases, each paired with the failure it would expose:
- Control-word stores that set the upper bits without changing bits 1:0. A missing mask would read back those upper bits. A flush-on-any-store would pulse `flush_all_req`.
- A context store that repeats the held value. A design that did not compare old and new would flush anyway.
- Two reads of fault status in a row. The second must return zero, while fault address stays intact; clearing the wrong index shows up here.
- A capture that coincides with the clearing read. A design that lets the clear win would lose the fault.
- Command-space levels 0, 1, 4, 5 and 15, and probe levels on both sides of 4. An off-by-one level bound shows up as a missing or extra pulse.

// File: rtl/mmuc_pkg.sv
package mmuc_pkg;
  localparam int unsigned IDX_W = 4;
  localparam int unsigned SEL_LSB = 8;

  localparam logic [7:0] SPC_CMD = 8'h03;
  localparam logic [7:0] SPC_REG = 8'h04;

  localparam logic [IDX_W-1:0] IDX_CTRL  = 4'd0;
  localparam logic [IDX_W-1:0] IDX_CTX   = 4'd2;
  localparam logic [IDX_W-1:0] IDX_FSTAT = 4'd3;
  localparam logic [IDX_W-1:0] IDX_FADDR = 4'd4;
  localparam logic [IDX_W-1:0] MAX_LEVEL = 4'd4;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_REG_RD,
    OP_REG_WR,
    OP_FLUSH,
    OP_PROBE,
    OP_PROBE_NULL,
    OP_NULL_RD
  } op_e;
endpackage

// File: rtl/mmuc_decode.sv
module mmuc_decode
  import mmuc_pkg::*;
#(
  parameter int unsigned SPACE_W = 8,
  parameter int unsigned ADDR_W  = 32
) (
  input  logic [SPACE_W-1:0] space,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rd,
  input  logic               wr,
  input  logic               busy,
  output op_e                op,
  output logic [IDX_W-1:0]   sel
);
  function automatic logic [IDX_W-1:0] field_of(input logic [ADDR_W-1:0] a);
    return a[SEL_LSB +: IDX_W];
  endfunction

  assign sel = field_of(addr);

  always_comb begin
    op = OP_IDLE;
    if (!busy) begin
      if (wr) begin
        if (space == SPACE_W'(SPC_REG))      op = OP_REG_WR;
        else if (space == SPACE_W'(SPC_CMD)) op = OP_FLUSH;
      end else if (rd) begin
        if (space == SPACE_W'(SPC_REG))      op = OP_REG_RD;
        else if (space == SPACE_W'(SPC_CMD)) op = (sel <= MAX_LEVEL) ? OP_PROBE : OP_PROBE_NULL;
        else                                 op = OP_NULL_RD;
      end
    end
  end
endmodule

// File: rtl/mmuc_regfile.sv
module mmuc_regfile
  import mmuc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] CTRL_MASK = 'h3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              hw_we,
  input  logic [DATA_W-1:0] hw_status,
  input  logic [DATA_W-1:0] hw_addr,
  output logic [DATA_W-1:0] rd_val,
  output logic              ctrl_chg,
  output logic              ctx_chg,
  output logic [DATA_W-1:0] fstat_q
);
  localparam int unsigned NREG = 1 << IDX_W;

  function automatic logic [DATA_W-1:0] merge_ctrl(input logic [DATA_W-1:0] old,
                                                   input logic [DATA_W-1:0] w);
    return (old & ~CTRL_MASK) | (w & CTRL_MASK);
  endfunction

  logic [NREG-1:0][DATA_W-1:0] regs;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [IDX_W-1:0] MY = g[IDX_W-1:0];
    logic [DATA_W-1:0] q;
    wire hit = wr_en && (idx == MY);
    if (MY == IDX_FSTAT) begin : g_fstat
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                      q <= '0;
        else if (hw_we)                  q <= hw_status;
        else if (rd_en && idx == MY)     q <= '0;
    end else if (MY == IDX_FADDR) begin : g_faddr
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)      q <= '0;
        else if (hw_we)  q <= hw_addr;
    end else if (MY == IDX_CTRL) begin : g_ctrl
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)    q <= '0;
        else if (hit)  q <= merge_ctrl(q, wdata);
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)    q <= '0;
        else if (hit)  q <= wdata;
    end
    assign regs[g] = q;
  end

  assign rd_val   = regs[idx];
  assign fstat_q  = regs[IDX_FSTAT];
  assign ctrl_chg = wr_en && (idx == IDX_CTRL) &&
                    (merge_ctrl(regs[IDX_CTRL], wdata) != regs[IDX_CTRL]);
  assign ctx_chg  = wr_en && (idx == IDX_CTX) && (wdata != regs[IDX_CTX]);
endmodule

// File: rtl/mmuc_flush.sv
module mmuc_flush
  import mmuc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PAGE_BITS = 12
) (
  input  logic              cmd,
  input  logic [IDX_W-1:0]  level,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ctrl_chg,
  input  logic              ctx_chg,
  output logic              page_req,
  output logic [ADDR_W-1:0] page_addr,
  output logic              all_req
);
  function automatic logic [ADDR_W-1:0] page_base(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
  endfunction

  wire lvl_zero  = (level == '0);
  wire lvl_broad = !lvl_zero && (level <= MAX_LEVEL);

  assign page_req  = cmd && lvl_zero;
  assign page_addr = page_base(addr);
  assign all_req   = (cmd && lvl_broad) || ctrl_chg || ctx_chg;
endmodule

// File: rtl/mmuc_probe.sv
module mmuc_probe (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic resp_valid,
  output logic busy,
  output logic done
);
  logic pend_q;
  assign busy = pend_q;
  assign done = pend_q && resp_valid;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     pend_q <= 1'b0;
    else if (start) pend_q <= 1'b1;
    else if (done)  pend_q <= 1'b0;
endmodule

// File: rtl/mmu_ctl_regs.sv
module mmu_ctl_regs
  import mmuc_pkg::*;
#(
  parameter int unsigned SPACE_W = 8,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter logic [DATA_W-1:0] CTRL_MASK = 'h3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SPACE_W-1:0] acc_space,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic [DATA_W-1:0]  acc_wdata,
  input  logic               acc_rd,
  input  logic               acc_wr,
  input  logic               hw_fault_we,
  input  logic [DATA_W-1:0]  hw_fault_status,
  input  logic [DATA_W-1:0]  hw_fault_addr,
  input  logic               probe_valid,
  input  logic [DATA_W-1:0]  probe_data,
  output logic               rd_valid,
  output logic [DATA_W-1:0]  rd_data,
  output logic               flush_page_req,
  output logic [ADDR_W-1:0]  flush_page_addr,
  output logic               flush_all_req,
  output logic               probe_req,
  output logic [IDX_W-1:0]   probe_level,
  output logic [ADDR_W-1:0]  probe_addr
);
  op_e               op;
  logic [IDX_W-1:0]  sel;
  logic              probe_busy, probe_done;
  logic [DATA_W-1:0] reg_val, fault_stat_q;
  logic              ctrl_chg, ctx_chg;
  logic              fl_page, fl_all;
  logic [ADDR_W-1:0] fl_addr;

  mmuc_decode #(.SPACE_W(SPACE_W), .ADDR_W(ADDR_W)) u_dec (
    .space(acc_space), .addr(acc_addr), .rd(acc_rd), .wr(acc_wr),
    .busy(probe_busy), .op(op), .sel(sel));

  wire evt_reg_wr     = (op == OP_REG_WR);
  wire evt_reg_rd     = (op == OP_REG_RD);
  wire evt_fstat_clr  = evt_reg_rd && (sel == IDX_FSTAT) && !hw_fault_we;
  wire evt_probe_go   = (op == OP_PROBE);
  wire evt_zero_rd    = (op == OP_PROBE_NULL) || (op == OP_NULL_RD);

  mmuc_regfile #(.DATA_W(DATA_W), .CTRL_MASK(CTRL_MASK)) u_rf (
    .clk(clk), .rst_n(rst_n), .wr_en(evt_reg_wr), .rd_en(evt_reg_rd), .idx(sel),
    .wdata(acc_wdata), .hw_we(hw_fault_we), .hw_status(hw_fault_status),
    .hw_addr(hw_fault_addr), .rd_val(reg_val), .ctrl_chg(ctrl_chg),
    .ctx_chg(ctx_chg), .fstat_q(fault_stat_q));

  mmuc_flush #(.ADDR_W(ADDR_W)) u_fl (
    .cmd(op == OP_FLUSH), .level(sel), .addr(acc_addr), .ctrl_chg(ctrl_chg),
    .ctx_chg(ctx_chg), .page_req(fl_page), .page_addr(fl_addr), .all_req(fl_all));

  mmuc_probe u_pr (
    .clk(clk), .rst_n(rst_n), .start(evt_probe_go), .resp_valid(probe_valid),
    .busy(probe_busy), .done(probe_done));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid        <= 1'b0;
      rd_data         <= '0;
      flush_page_req  <= 1'b0;
      flush_page_addr <= '0;
      flush_all_req   <= 1'b0;
      probe_req       <= 1'b0;
      probe_level     <= '0;
      probe_addr      <= '0;
    end else begin
      rd_valid        <= evt_reg_rd || evt_zero_rd || probe_done;
      rd_data         <= evt_reg_rd ? reg_val : (probe_done ? probe_data : '0);
      flush_page_req  <= fl_page;
      flush_page_addr <= fl_page ? fl_addr : '0;
      flush_all_req   <= fl_all;
      probe_req       <= evt_probe_go;
      probe_level     <= evt_probe_go ? sel : '0;
      probe_addr      <= evt_probe_go ? acc_addr : '0;
    end
  end
endmodule

// File: rtl/mmuc_chk.sv
module mmuc_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_rd,
  input logic              acc_wr,
  input logic              probe_valid,
  input logic              rd_valid,
  input logic              flush_page_req,
  input logic [ADDR_W-1:0] flush_page_addr,
  input logic              flush_all_req,
  input logic              probe_req,
  input logic [3:0]        probe_level,
  input logic              evt_fstat_clr,
  input logic [DATA_W-1:0] fault_stat_q
);
  // R12
  flush_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(flush_page_req && flush_all_req));
  // R7
  page_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_page_req |-> (flush_page_addr[11:0] == 12'h000));
  // R9
  probe_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    probe_req |-> (probe_level <= 4'd4));
  // R12
  probe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    probe_req |=> !probe_req);
  // R5
  fstat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_fstat_clr |=> (fault_stat_q == '0));
  // R2
  rd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(acc_rd) || $past(probe_valid)));
  // R3
  flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all_req || flush_page_req) |-> $past(acc_wr));
endmodule

bind mmu_ctl_regs mmuc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
  .probe_valid(probe_valid), .rd_valid(rd_valid), .flush_page_req(flush_page_req),
  .flush_page_addr(flush_page_addr), .flush_all_req(flush_all_req),
  .probe_req(probe_req), .probe_level(probe_level),
  .evt_fstat_clr(evt_fstat_clr), .fault_stat_q(fault_stat_q));

// File: tb/mmu_ctl_regs_tb.sv
module mmu_ctl_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  acc_space = '0;
  logic [31:0] acc_addr = '0, acc_wdata = '0;
  logic        acc_rd = 1'b0, acc_wr = 1'b0;
  logic        hw_fault_we = 1'b0;
  logic [31:0] hw_fault_status = '0, hw_fault_addr = '0;
  logic        probe_valid = 1'b0;
  logic [31:0] probe_data = '0;
  logic        rd_valid, flush_page_req, flush_all_req, probe_req;
  logic [31:0] rd_data, flush_page_addr, probe_addr;
  logic [3:0]  probe_level;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mmu_ctl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .acc_space(acc_space), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .hw_fault_we(hw_fault_we), .hw_fault_status(hw_fault_status),
    .hw_fault_addr(hw_fault_addr), .probe_valid(probe_valid), .probe_data(probe_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .flush_page_req(flush_page_req),
    .flush_page_addr(flush_page_addr), .flush_all_req(flush_all_req),
    .probe_req(probe_req), .probe_level(probe_level), .probe_addr(probe_addr));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] at(input logic [3:0] sel, input logic [11:0] hi_lo = 12'h0);
    return {20'h12345, sel, hi_lo[7:0]};
  endfunction

  // One access; outputs sampled at the negedge after the registering edge.
  task automatic access(input bit wr, input logic [7:0] sp, input logic [31:0] a,
                        input logic [31:0] d);
    @(negedge clk);
    acc_space = sp; acc_addr = a; acc_wdata = d; acc_wr = wr; acc_rd = !wr;
    @(negedge clk);
    acc_wr = 1'b0; acc_rd = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] i, input logic [31:0] exp, input string tag);
    access(1'b0, 8'h04, at(i), '0);
    chk({tag, " rd_valid"}, {31'b0, rd_valid}, 32'd1);
    chk({tag, " rd_data"}, rd_data, exp);
  endtask

  task automatic wr_reg(input logic [3:0] i, input logic [31:0] d, input bit exp_flush,
                        input string tag);
    access(1'b1, 8'h04, at(i), d);
    chk({tag, " flush_all"}, {31'b0, flush_all_req}, {31'b0, exp_flush});
    chk({tag, " flush_page"}, {31'b0, flush_page_req}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 rd_valid", {31'b0, rd_valid}, 32'd0);
    chk("R1 flush_all", {31'b0, flush_all_req}, 32'd0);
    chk("R1 probe_req", {31'b0, probe_req}, 32'd0);
    for (int i = 0; i < 16; i++) rd_reg(i[3:0], 32'h0, "R1 reg");
  endtask

  task automatic t_plain;
    wr_reg(4'd5, 32'hDEAD_BEEF, 1'b0, "R6 wr5");
    wr_reg(4'd15, 32'h0F0F_1234, 1'b0, "R6 wr15");
    rd_reg(4'd5, 32'hDEAD_BEEF, "R2 rd5");
    rd_reg(4'd15, 32'h0F0F_1234, "R2 rd15");
  endtask

  task automatic t_ctrl;
    wr_reg(4'd0, 32'hFFFF_FFFF, 1'b1, "R3 set");
    rd_reg(4'd0, 32'h3, "R3 masked");
    wr_reg(4'd0, 32'hABCD_0003, 1'b0, "R3 same bits");
    wr_reg(4'd0, 32'h0000_0002, 1'b1, "R3 enable off");
    @(negedge clk);
    chk("R12 flush pulse", {31'b0, flush_all_req}, 32'd0);
    rd_reg(4'd0, 32'h2, "R3 readback");
  endtask

  task automatic t_ctx;
    wr_reg(4'd2, 32'h0000_1234, 1'b1, "R4 change");
    wr_reg(4'd2, 32'h0000_1234, 1'b0, "R4 same");
    rd_reg(4'd2, 32'h0000_1234, "R4 readback");
  endtask

  task automatic t_fault;
    @(negedge clk);
    hw_fault_we = 1'b1; hw_fault_status = 32'h0000_00A5; hw_fault_addr = 32'h0000_BEEF;
    @(negedge clk);
    hw_fault_we = 1'b0;
    wr_reg(4'd3, 32'h55, 1'b0, "R6 wr3");
    wr_reg(4'd4, 32'h66, 1'b0, "R6 wr4");
    rd_reg(4'd4, 32'h0000_BEEF, "R6 faddr kept");
    rd_reg(4'd3, 32'h0000_00A5, "R5 first read");
    rd_reg(4'd3, 32'h0, "R5 cleared");
    rd_reg(4'd4, 32'h0000_BEEF, "R5 faddr intact");
    // capture coinciding with a clearing read
    @(negedge clk);
    hw_fault_we = 1'b1; hw_fault_status = 32'h77; hw_fault_addr = 32'h88;
    acc_space = 8'h04; acc_addr = at(4'd3); acc_rd = 1'b1;
    @(negedge clk);
    hw_fault_we = 1'b0; acc_rd = 1'b0;
    chk("R5 coincide old", rd_data, 32'h0);
    rd_reg(4'd3, 32'h77, "R5 capture wins");
  endtask

  task automatic t_flush;
    access(1'b1, 8'h03, 32'h1234_50AC, 32'h0);
    chk("R7 page req", {31'b0, flush_page_req}, 32'd1);
    chk("R7 page addr", flush_page_addr, 32'h1234_5000);
    chk("R7 no all", {31'b0, flush_all_req}, 32'd0);
    for (int l = 1; l < 16; l++) begin
      access(1'b1, 8'h03, {20'hABCDE, l[3:0], 8'h10}, 32'h0);
      chk($sformatf("R8 level %0d all", l), {31'b0, flush_all_req}, (l <= 4) ? 32'd1 : 32'd0);
      chk($sformatf("R8 level %0d page", l), {31'b0, flush_page_req}, 32'd0);
    end
  endtask

  task automatic t_probe;
    access(1'b0, 8'h03, 32'h0040_0210, 32'h0);
    chk("R9 probe_req", {31'b0, probe_req}, 32'd1);
    chk("R9 level", {28'b0, probe_level}, 32'd2);
    chk("R9 addr", probe_addr, 32'h0040_0210);
    chk("R9 no data yet", {31'b0, rd_valid}, 32'd0);
    probe_valid = 1'b1; probe_data = 32'hCAFE_F00D;
    @(negedge clk);
    probe_valid = 1'b0;
    chk("R12 probe pulse", {31'b0, probe_req}, 32'd0);
    chk("R9 resp valid", {31'b0, rd_valid}, 32'd1);
    chk("R9 resp data", rd_data, 32'hCAFE_F00D);
    access(1'b0, 8'h03, 32'h0000_0700, 32'h0);
    chk("R10 valid", {31'b0, rd_valid}, 32'd1);
    chk("R10 zero", rd_data, 32'h0);
    chk("R10 no probe", {31'b0, probe_req}, 32'd0);
  endtask

  task automatic t_other;
    access(1'b0, 8'h20, at(4'd5), '0);
    chk("R11 valid", {31'b0, rd_valid}, 32'd1);
    chk("R11 zero", rd_data, 32'h0);
    access(1'b1, 8'h11, at(4'd5), 32'h1111_2222);
    chk("R11 no flush", {31'b0, flush_all_req | flush_page_req}, 32'd0);
    rd_reg(4'd5, 32'hDEAD_BEEF, "R11 reg5 intact");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 20000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_ctrl();
    t_ctx();
    t_fault();
    t_flush();
    t_probe();
    t_other();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule